// File: doc/BRIEF.md
# Interline Image Sensor Drive Sequencer

This block generates every digital drive line needed to read an interline-transfer area-array image sensor through a single output channel. Each frame runs a fixed sequence:

1. A shutter pulse empties the photosites.
2. Integration runs for a programmable number of line periods.
3. A top-level step on the three-level vertical clock moves all photosite charge into the shielded vertical registers.
4. The rows are shifted toward the horizontal register one at a time. After each shift, a full line of pixels is clocked out, and each line carries dark reference pixels at both ends.

The three-level vertical phase leaves the block as two binary control lines, which an external driver combines into the analog levels. Every output is registered. Reset drives every output low, and low is the inactive level.

A frame starts when `run` is high while the block is idle, or when `run` is high at the last clock of the previous frame. Exposure length and the clocks-per-pixel divider are captured when a frame starts. Array geometry and the fixed pulse widths are parameters. The block moves no data, so it has no valid/ready stream. `pix_valid` is a timing strobe for an external sampler. It cannot be back-pressured, so the sampler must accept one sample per pixel period.

Top module: `ilt_drive_gen`

## Requirements
- R1: While `rst_n` is low, and afterwards while `run` stays low, every output is 0. A reset in the middle of a frame returns every output to 0 on the next clock.
- R2: `frame_start` is a one-clock pulse in the same cycle that `shut_pulse` rises. `shut_pulse` stays high for exactly SHUT_CYC clocks, and all vertical and horizontal lines stay low while it is high.
- R3: The number of clocks from the first cycle after `shut_pulse` falls until `vb_mid` rises equals `expo_lines` × ((ACT_COLS + 2·DARK_COLS) × div + 2·VHALF_CYC). Here div is the effective pixel divider. An exposure of 0 makes the transfer start directly after the shutter pulse.
- R4: The vertical level code is {`vb_hi`,`vb_mid`}: 00 is low, 01 is middle and 11 is high, and 10 never occurs. Once per frame the transfer runs as follows: middle for MID_CYC clocks, then high for XFER_CYC clocks, then middle for MID_CYC clocks. The step from high to middle is marked by `vb_hi` falling while `vb_mid` stays 1.
- R5: Before each line readout, `vclk_a` is high for VHALF_CYC clocks while the level is low. The level is then middle for VHALF_CYC clocks while `vclk_a` is low. `vclk_a` and `vb_mid` are never high together, and `vclk_a` pulses ACT_ROWS times per frame.
- R6: Each line has ACT_COLS + 2·DARK_COLS pixel periods of div clocks each. Within a pixel period with phase p = 0…div−1:
  - `hclk_a` is high for p in 1…div/2−1, which is div/2−1 clocks.
  - `hclk_b` is high for p in div/2+1…div−1.
  - The two are never high together.
- R7: `node_rst` is high for one clock per pixel, at p = 2, and is only ever high or falling while `hclk_a` is high.
- R8: `pix_valid` pulses once per pixel at p = div−1, while `hclk_b` is high. `pix_dark` pulses together with it for the first and last DARK_COLS pixels of each line.
- R9: While `vclk_a` or `vb_mid` is high, `hclk_a`, `hclk_b` and `node_rst` are low.
- R10: A `pix_div` value below 8 is treated as 8.
- R11: Changes to `expo_lines` or `pix_div` during a frame have no effect until the next frame starts.
- R12: If `run` is high at the last clock of a frame, the next `frame_start` follows immediately. The frame period is then SHUT_CYC + expo·L + 2·MID_CYC + XFER_CYC + ACT_ROWS·(2·VHALF_CYC + (ACT_COLS+2·DARK_COLS)·div), where L is the line period from R3. If `run` is low at that clock, the block goes idle with all outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start request; sampled when idle and at frame end |
| expo_lines | input | EXPO_W | Integration length in line periods |
| pix_div | input | DIV_W | System clocks per pixel period (minimum 8) |
| shut_pulse | output | 1 | Photosite clear pulse |
| frame_start | output | 1 | One-clock pulse at the start of a frame |
| vclk_a | output | 1 | Two-level vertical phase |
| vb_hi | output | 1 | Vertical three-level code, high-level bit |
| vb_mid | output | 1 | Vertical three-level code, middle-or-above bit |
| hclk_a | output | 1 | Horizontal phase A (charge moved to output node) |
| hclk_b | output | 1 | Horizontal phase B |
| node_rst | output | 1 | Output node reset pulse |
| pix_valid | output | 1 | Sampling strobe, one per pixel |
| pix_dark | output | 1 | Marks the strobe of a dark reference pixel |

## Verification
Single frames are run over a table of exposure and divider pairs:
- An exposure of zero separates an empty integration from an off-by-one line count, and exposures of 1 to 3 confirm the count grows with the value.
- Dividers of 8, 9 and 10 show whether the phase split follows the even or odd width.
- A divider of 5 shows whether the minimum is enforced.

One frame changes both inputs after its start, which shows whether they were captured at frame start. Directed runs cover continuous operation, where the frame-to-frame period must match the closed-form length, and a reset issued during readout.

// File: rtl/ilt_pkg.sv
package ilt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHUT,
    ST_INTEG,
    ST_XFER,
    ST_VSH,
    ST_HRD
  } phase_t;

  // bit 1: high level selected, bit 0: middle level or above
  typedef enum logic [1:0] {
    VL_LOW  = 2'b00,
    VL_MID  = 2'b01,
    VL_HIGH = 2'b11
  } vlev_t;

  localparam int unsigned MIN_DIV = 8;

endpackage

// File: rtl/ilt_frame_ctl.sv
module ilt_frame_ctl
  import ilt_pkg::*;
#(
  parameter int unsigned ACT_COLS  = 640,
  parameter int unsigned ACT_ROWS  = 480,
  parameter int unsigned DARK_COLS = 24,
  parameter int unsigned SHUT_CYC  = 16,
  parameter int unsigned MID_CYC   = 4,
  parameter int unsigned XFER_CYC  = 32,
  parameter int unsigned VHALF_CYC = 8,
  parameter int unsigned EXPO_W    = 16,
  parameter int unsigned DIV_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [EXPO_W-1:0] expo_lines,
  input  logic [DIV_W-1:0]  pix_div,
  output phase_t            phase_o,
  output logic [31:0]       cnt_o,
  output logic [31:0]       ph_o,
  output logic [31:0]       col_o,
  output logic [31:0]       div_o,
  output logic              fstart_o
);

  localparam int unsigned NPIX   = ACT_COLS + 2 * DARK_COLS;
  localparam int unsigned XFER_T = 2 * MID_CYC + XFER_CYC;
  localparam int unsigned VSH_T  = 2 * VHALF_CYC;

  phase_t      phase;
  logic [31:0] cnt, ph, col, row, ln, div_q, expo_q;
  logic [31:0] div_in, expo_in, line_t;
  logic        pix_end, line_end, rows_done;

  always_comb begin
    div_in    = (32'(pix_div) < MIN_DIV) ? MIN_DIV : 32'(pix_div);
    expo_in   = 32'(expo_lines);
    line_t    = NPIX * div_q + VSH_T;
    pix_end   = (ph == div_q - 1);
    line_end  = pix_end && (col == NPIX - 1);
    rows_done = (row == ACT_ROWS - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= ST_IDLE;
      cnt    <= '0;
      ph     <= '0;
      col    <= '0;
      row    <= '0;
      ln     <= '0;
      div_q  <= MIN_DIV;
      expo_q <= '0;
    end else begin
      unique case (phase)
        ST_IDLE: begin
          if (run) begin
            phase  <= ST_SHUT;
            cnt    <= '0;
            div_q  <= div_in;
            expo_q <= expo_in;
          end
        end
        ST_SHUT: begin
          if (cnt == SHUT_CYC - 1) begin
            cnt   <= '0;
            ln    <= '0;
            phase <= (expo_q == 0) ? ST_XFER : ST_INTEG;
          end else begin
            cnt <= cnt + 1;
          end
        end
        ST_INTEG: begin
          if (cnt == line_t - 1) begin
            cnt <= '0;
            if (ln == expo_q - 1) phase <= ST_XFER;
            else                  ln    <= ln + 1;
          end else begin
            cnt <= cnt + 1;
          end
        end
        ST_XFER: begin
          if (cnt == XFER_T - 1) begin
            cnt   <= '0;
            row   <= '0;
            phase <= ST_VSH;
          end else begin
            cnt <= cnt + 1;
          end
        end
        ST_VSH: begin
          if (cnt == VSH_T - 1) begin
            cnt   <= '0;
            ph    <= '0;
            col   <= '0;
            phase <= ST_HRD;
          end else begin
            cnt <= cnt + 1;
          end
        end
        ST_HRD: begin
          if (pix_end) begin
            ph <= '0;
            if (line_end) begin
              col <= '0;
              cnt <= '0;
              if (rows_done) begin
                if (run) begin
                  phase  <= ST_SHUT;
                  div_q  <= div_in;
                  expo_q <= expo_in;
                end else begin
                  phase <= ST_IDLE;
                end
              end else begin
                row   <= row + 1;
                phase <= ST_VSH;
              end
            end else begin
              col <= col + 1;
            end
          end else begin
            ph <= ph + 1;
          end
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  assign phase_o  = phase;
  assign cnt_o    = cnt;
  assign ph_o     = ph;
  assign col_o    = col;
  assign div_o    = div_q;
  assign fstart_o = (phase == ST_SHUT) && (cnt == 0);

endmodule

// File: rtl/ilt_vclk.sv
module ilt_vclk
  import ilt_pkg::*;
#(
  parameter int unsigned MID_CYC   = 4,
  parameter int unsigned XFER_CYC  = 32,
  parameter int unsigned VHALF_CYC = 8
) (
  input  phase_t      phase,
  input  logic [31:0] cnt,
  output logic        va,
  output vlev_t       lvl
);

  localparam int unsigned HI_END = MID_CYC + XFER_CYC;

  always_comb begin
    va  = 1'b0;
    lvl = VL_LOW;
    case (phase)
      ST_XFER: begin
        if (cnt < MID_CYC)     lvl = VL_MID;
        else if (cnt < HI_END) lvl = VL_HIGH;
        else                   lvl = VL_MID;
      end
      ST_VSH: begin
        if (cnt < VHALF_CYC) va  = 1'b1;
        else                 lvl = VL_MID;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ilt_hclk.sv
module ilt_hclk #(
  parameter int unsigned ACT_COLS  = 640,
  parameter int unsigned DARK_COLS = 24
) (
  input  logic        en,
  input  logic [31:0] ph,
  input  logic [31:0] div,
  input  logic [31:0] col,
  output logic        ha,
  output logic        hb,
  output logic        nrst,
  output logic        pv,
  output logic        dark
);

  localparam int unsigned DARK_HI = DARK_COLS + ACT_COLS;

  logic [31:0] half;

  always_comb begin
    half = div >> 1;
    ha   = en && (ph >= 1) && (ph < half);
    hb   = en && (ph > half);
    nrst = en && (ph == 2);
    pv   = en && (ph == div - 1);
    dark = pv && ((col < DARK_COLS) || (col >= DARK_HI));
  end

endmodule

// File: rtl/ilt_drive_gen.sv
module ilt_drive_gen
  import ilt_pkg::*;
#(
  parameter int unsigned ACT_COLS  = 640,
  parameter int unsigned ACT_ROWS  = 480,
  parameter int unsigned DARK_COLS = 24,
  parameter int unsigned SHUT_CYC  = 16,
  parameter int unsigned MID_CYC   = 4,
  parameter int unsigned XFER_CYC  = 32,
  parameter int unsigned VHALF_CYC = 8,
  parameter int unsigned EXPO_W    = 16,
  parameter int unsigned DIV_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [EXPO_W-1:0] expo_lines,
  input  logic [DIV_W-1:0]  pix_div,
  output logic              shut_pulse,
  output logic              frame_start,
  output logic              vclk_a,
  output logic              vb_hi,
  output logic              vb_mid,
  output logic              hclk_a,
  output logic              hclk_b,
  output logic              node_rst,
  output logic              pix_valid,
  output logic              pix_dark
);

  phase_t      phase;
  logic [31:0] cnt, ph, col, div_q;
  logic        fstart, va_n, ha_n, hb_n, nr_n, pv_n, dk_n;
  vlev_t       lvl_n;

  ilt_frame_ctl #(
    .ACT_COLS (ACT_COLS),  .ACT_ROWS (ACT_ROWS),  .DARK_COLS(DARK_COLS),
    .SHUT_CYC (SHUT_CYC),  .MID_CYC  (MID_CYC),   .XFER_CYC (XFER_CYC),
    .VHALF_CYC(VHALF_CYC), .EXPO_W   (EXPO_W),    .DIV_W    (DIV_W)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .run(run), .expo_lines(expo_lines),
    .pix_div(pix_div), .phase_o(phase), .cnt_o(cnt), .ph_o(ph),
    .col_o(col), .div_o(div_q), .fstart_o(fstart)
  );

  ilt_vclk #(
    .MID_CYC(MID_CYC), .XFER_CYC(XFER_CYC), .VHALF_CYC(VHALF_CYC)
  ) u_vclk (
    .phase(phase), .cnt(cnt), .va(va_n), .lvl(lvl_n)
  );

  ilt_hclk #(
    .ACT_COLS(ACT_COLS), .DARK_COLS(DARK_COLS)
  ) u_hclk (
    .en(phase == ST_HRD), .ph(ph), .div(div_q), .col(col),
    .ha(ha_n), .hb(hb_n), .nrst(nr_n), .pv(pv_n), .dark(dk_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shut_pulse  <= 1'b0;
      frame_start <= 1'b0;
      vclk_a      <= 1'b0;
      vb_hi       <= 1'b0;
      vb_mid      <= 1'b0;
      hclk_a      <= 1'b0;
      hclk_b      <= 1'b0;
      node_rst    <= 1'b0;
      pix_valid   <= 1'b0;
      pix_dark    <= 1'b0;
    end else begin
      shut_pulse  <= (phase == ST_SHUT);
      frame_start <= fstart;
      vclk_a      <= va_n;
      vb_hi       <= lvl_n[1];
      vb_mid      <= lvl_n[0];
      hclk_a      <= ha_n;
      hclk_b      <= hb_n;
      node_rst    <= nr_n;
      pix_valid   <= pv_n;
      pix_dark    <= dk_n;
    end
  end

endmodule

// File: rtl/ilt_drive_chk.sv
module ilt_drive_chk (
  input logic clk,
  input logic rst_n,
  input logic shut_pulse,
  input logic frame_start,
  input logic vclk_a,
  input logic vb_hi,
  input logic vb_mid,
  input logic hclk_a,
  input logic hclk_b,
  input logic node_rst,
  input logic pix_valid,
  input logic pix_dark
);

  AST_H_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hclk_a && hclk_b)); // R6
  AST_NRST_IN_HA: assert property (@(posedge clk) disable iff (!rst_n)
    node_rst |-> hclk_a); // R7
  AST_NRST_FALL_IN_HA: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(node_rst) |-> hclk_a); // R7
  AST_VCODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    vb_hi |-> vb_mid); // R4
  AST_HI_FROM_MID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vb_hi) |-> $past(vb_mid)); // R4
  AST_HI_TO_MID: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vb_hi) |-> vb_mid); // R4
  AST_V_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    vclk_a |-> !vb_mid); // R5
  AST_H_QUIET_IN_V: assert property (@(posedge clk) disable iff (!rst_n)
    (vclk_a || vb_mid) |-> !(hclk_a || hclk_b || node_rst)); // R9
  AST_SHUT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    shut_pulse |-> !(vclk_a || vb_mid || hclk_a || hclk_b)); // R2
  AST_FS_AT_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shut_pulse) |-> frame_start); // R2
  AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start); // R2
  AST_PV_IN_HB: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> hclk_b); // R8
  AST_DARK_WITH_PV: assert property (@(posedge clk) disable iff (!rst_n)
    pix_dark |-> pix_valid); // R8

endmodule

bind ilt_drive_gen ilt_drive_chk u_chk (
  .clk(clk), .rst_n(rst_n), .shut_pulse(shut_pulse), .frame_start(frame_start),
  .vclk_a(vclk_a), .vb_hi(vb_hi), .vb_mid(vb_mid), .hclk_a(hclk_a),
  .hclk_b(hclk_b), .node_rst(node_rst), .pix_valid(pix_valid), .pix_dark(pix_dark)
);

// File: tb/test_ilt_drive_gen.sv
module test_ilt_drive_gen;

  localparam int COLS = 8, DARK = 24, ROWS = 3, SHUT = 6, MIDC = 2, XFC = 5, VH = 3;
  localparam int NPIX = COLS + 2 * DARK;
  localparam int NVEC = 5;
  // fields: exposure [31:16], divider [15:8], change-after-start flag [0]
  localparam logic [31:0] VECS [NVEC] = '{
    {16'd2, 8'd8,  8'd0},
    {16'd0, 8'd10, 8'd0},
    {16'd1, 8'd5,  8'd0},
    {16'd3, 8'd9,  8'd0},
    {16'd2, 8'd8,  8'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, clr = 1'b0;
  logic [15:0] expo = '0;
  logic [7:0]  pdiv = 8'd8;
  logic shut_pulse, frame_start, vclk_a, vb_hi, vb_mid;
  logic hclk_a, hclk_b, node_rst, pix_valid, pix_dark;

  always #5 clk = ~clk;

  ilt_drive_gen #(
    .ACT_COLS(COLS), .ACT_ROWS(ROWS), .DARK_COLS(DARK), .SHUT_CYC(SHUT),
    .MID_CYC(MIDC), .XFER_CYC(XFC), .VHALF_CYC(VH), .EXPO_W(16), .DIV_W(8)
  ) i_ilt_drive_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .expo_lines(expo), .pix_div(pdiv),
    .shut_pulse(shut_pulse), .frame_start(frame_start), .vclk_a(vclk_a),
    .vb_hi(vb_hi), .vb_mid(vb_mid), .hclk_a(hclk_a), .hclk_b(hclk_b),
    .node_rst(node_rst), .pix_valid(pix_valid), .pix_dark(pix_dark)
  );

  int checks = 0, fails = 0;
  int sh_w, gap, hi_w, hi_rise, v1_rise, h1_rise, h1_run, h1_w, rl_cnt, rl_bad;
  int pv_cnt, dk_cnt, ovl, sep_bad, fs_cnt, act_cnt, cyc, last_fs, period;
  bit gapping;
  logic p_sh = 0, p_h1 = 0, p_hi = 0, p_v1 = 0;
  logic act;

  assign act = shut_pulse | frame_start | vclk_a | vb_hi | vb_mid | hclk_a |
               hclk_b | node_rst | pix_valid | pix_dark;

  always @(negedge clk) begin
    cyc++;
    if (clr) begin
      sh_w = 0; gap = 0; hi_w = 0; hi_rise = 0; v1_rise = 0; h1_rise = 0;
      h1_run = 0; h1_w = 0; rl_cnt = 0; rl_bad = 0; pv_cnt = 0; dk_cnt = 0;
      ovl = 0; sep_bad = 0; fs_cnt = 0; act_cnt = 0; period = 0; gapping = 0;
    end else begin
      if (shut_pulse) sh_w++;
      if (p_sh && !shut_pulse) begin
        gap = vb_mid ? 0 : 1;
        gapping = !vb_mid;
      end else if (gapping) begin
        if (vb_mid) gapping = 0;
        else gap++;
      end
      if (vb_hi) hi_w++;
      if (vb_hi && !p_hi) hi_rise++;
      if (vclk_a && !p_v1) v1_rise++;
      if (hclk_a && !p_h1) h1_rise++;
      if (hclk_a) h1_run++;
      else if (p_h1) begin h1_w = h1_run; h1_run = 0; end
      if (node_rst) rl_cnt++;
      if (node_rst && !hclk_a) rl_bad++;
      if (pix_valid) pv_cnt++;
      if (pix_dark) dk_cnt++;
      if (hclk_a && hclk_b) ovl++;
      if ((vclk_a || vb_mid) && (hclk_a || hclk_b || node_rst)) sep_bad++;
      if (frame_start) begin
        fs_cnt++;
        period = cyc - last_fs;
        last_fs = cyc;
      end
      if (act) act_cnt++;
    end
    p_sh = shut_pulse; p_h1 = hclk_a; p_hi = vb_hi; p_v1 = vclk_a;
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic clear();
    clr = 1'b1;
    tick();
    tick();
    clr = 1'b0;
  endtask

  task automatic chk(input string req, input int actv, input int expv);
    checks++;
    if (actv != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actv, expv);
    end
  endtask

  function automatic int eff(input int d);
    return (d < 8) ? 8 : d;
  endfunction

  function automatic int line_len(input int d);
    return NPIX * d + 2 * VH;
  endfunction

  function automatic int frame_len(input int e, input int d);
    return SHUT + e * line_len(d) + 2 * MIDC + XFC + ROWS * (2 * VH + NPIX * d);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual 200000 cycles expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int fl;
    clr = 1'b1;
    repeat (3) tick();
    chk("R1 outputs low in reset", int'(act), 0);
    rst_n = 1'b1;
    clr = 1'b0;
    repeat (40) tick();
    chk("R1 idle while run low", act_cnt, 0);

    // table of single frames
    for (int i = 0; i < NVEC; i++) begin
      int e, d, ed;
      e  = int'(VECS[i][31:16]);
      d  = int'(VECS[i][15:8]);
      ed = eff(d);
      expo = 16'(e);
      pdiv = 8'(d);
      clear();
      run = 1'b1;
      while (fs_cnt == 0) tick();
      run = 1'b0;
      if (VECS[i][0]) begin
        repeat (3) tick();
        expo = 16'd0;
        pdiv = 8'd20;
      end
      repeat (frame_len(e, ed) + 20) tick();
      chk("R2 one frame_start", fs_cnt, 1);
      chk("R2 shutter width", sh_w, SHUT);
      chk(VECS[i][0] ? "R11 integration with late change" : "R3 integration length",
          gap, e * line_len(ed));
      chk("R4 high level width", hi_w, XFC);
      chk("R4 one high step", hi_rise, 1);
      chk("R5 line shifts", v1_rise, ROWS);
      chk("R6 pixel count", h1_rise, ROWS * NPIX);
      chk(d < 8 ? "R10 clamped phase width" : "R6 phase A width", h1_w, ed / 2 - 1);
      chk("R6 no phase overlap", ovl, 0);
      chk("R7 node reset count", rl_cnt, ROWS * NPIX);
      chk("R7 node reset inside phase A", rl_bad, 0);
      chk("R8 strobe count", pv_cnt, ROWS * NPIX);
      chk("R8 dark strobe count", dk_cnt, ROWS * 2 * DARK);
      chk("R9 horizontal quiet during vertical", sep_bad, 0);
      chk("R12 idle after frame", int'(act), 0);
    end

    // continuous run: back-to-back frames
    expo = 16'd1;
    pdiv = 8'd8;
    fl = frame_len(1, 8);
    clear();
    run = 1'b1;
    while (fs_cnt < 2) tick();
    run = 1'b0;
    chk("R12 back-to-back frame period", period, fl);
    repeat (fl + 20) tick();
    chk("R12 stop after run drops", fs_cnt, 2);
    chk("R12 idle after last frame", int'(act), 0);

    // reset during readout
    clear();
    run = 1'b1;
    while (fs_cnt == 0) tick();
    run = 1'b0;
    repeat (fl - 200) tick();
    rst_n = 1'b0;
    tick();
    chk("R1 mid-frame reset clears outputs", int'(act), 0);
    repeat (3) tick();
    rst_n = 1'b1;
    clear();
    repeat (40) tick();
    chk("R1 idle after mid-frame reset", act_cnt, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule